// File: doc/BRIEF.md
# Per-Line Outstanding Request Tracker

This block sits between a requester and its cache controller. It keeps track of the memory requests that are still in flight, one per cache line, so that no line ever has two accesses outstanding. Each request carries an address, a byte length and a kind. The block answers every request one cycle later with a status: issued, refused because the line is busy, refused because the table for that class is full, or refused as malformed. Requests that write or claim ownership of a line are held in a write table. Plain loads and instruction fetches are held in a separate read table. A completion naming an address frees the entry for that line.

Every entry keeps its own age counter. When an entry has been outstanding for a set number of cycles, the block raises a one-cycle stall warning. The warning reports the line and the cycle stamp at which that entry was inserted. Issued requests receive increasing IDs. The response also tells whether the request returns line data to the requester or merges requester data into the line. Moving data and looking up the cache are left to the blocks around it.

Top module: `req_tracker`

## Requirements
- R1: After reset both tables are empty, `resp_valid` and `stall_valid` are low, and the first issued request gets ID 0.
- R2: Kinds are coded as load=0, fetch=2'b... as follows: load=0 and fetch=1 go to the read table; store=2, atomic-read=3, atomic-write=4, reserve-read=5 and reserve-write=6 go to the write table. A full write table does not block a read-class request, and the reverse also holds.
- R3: The line is `addr >> log2(BLOCK_BYTES)`. A request whose line already has an entry in either table is refused with status 1 (busy). The lookup sees the tables as they were before any completion in the same cycle.
- R4: A request whose in-line offset plus length exceeds BLOCK_BYTES, or whose kind is 7, is refused with status 3 (malformed). An offset plus length equal to BLOCK_BYTES is legal.
- R5: A completion frees the entry holding its line, so that line can be issued from the next cycle on. A completion for a line with no entry changes nothing.
- R6: A well-formed request to a free line whose class table already holds DEPTH entries is refused with status 2 (full). The checks are ranked malformed, then busy, then full.
- R7: Each issued request (status 0) gets an ID one greater than the previous issued request. Refused requests consume no ID.
- R8: For an issued request, `resp_data_back` is 1 for load, fetch and atomic-read, and 0 for the other kinds.
- R9: An entry still outstanding STALL_CYCLES edges after its insertion edge raises `stall_valid` for one cycle, on the following edge. The warning carries its line and the insertion stamp. The stamp is a cycle counter that is 0 in the first cycle after reset. Each entry warns at most once, and the write table is reported before the read table.
- R10: `resp_valid` is high exactly in the cycle after a cycle with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | LEN_W | Length in bytes |
| req_kind | input | 3 | Request kind code |
| cpl_valid | input | 1 | Completion present this cycle |
| cpl_addr | input | ADDR_W | Address whose line has completed |
| resp_valid | output | 1 | Response to the previous cycle's request |
| resp_status | output | 2 | 0 issued, 1 busy, 2 full, 3 malformed |
| resp_id | output | ID_W | ID of the issued request |
| resp_data_back | output | 1 | 1: data returns to requester, 0: data merges into line |
| stall_valid | output | 1 | Possible deadlock warning pulse |
| stall_line | output | LINE_W | Line of the stalled entry |
| stall_stamp | output | TS_W | Insertion stamp of the stalled entry |

## Verification
A lost or stale valid bit shows up on the very next request to that line. A leaked entry answers busy where issued was expected. An entry dropped too early lets a second access through. A miscount of occupancy changes the full status exactly at the ninth same-class request. A wrong class choice shows because a full write table then blocks loads. Age counters that misbehave move the stall pulse off its exact cycle, or repeat it, or let it fire for an entry that has already completed. All of these appear within one response, or within one stall window.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;

  typedef enum logic [2:0] {
    K_LOAD    = 3'd0,
    K_FETCH   = 3'd1,
    K_STORE   = 3'd2,
    K_ATOM_RD = 3'd3,
    K_ATOM_WR = 3'd4,
    K_RSV_RD  = 3'd5,
    K_RSV_WR  = 3'd6,
    K_RSVD    = 3'd7
  } kind_e;

  typedef enum logic [1:0] {
    ST_ISSUE = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FULL  = 2'd2,
    ST_BAD   = 2'd3
  } status_e;

  // write-class kinds own the line; read-class only sample it
  function automatic logic is_write_class(input logic [2:0] k);
    return (k >= 3'd2) && (k <= 3'd6);
  endfunction

  // data flows back to the requester for these kinds
  function automatic logic returns_data(input logic [2:0] k);
    return (k == 3'd0) || (k == 3'd1) || (k == 3'd3);
  endfunction

  // access must stay inside one line
  function automatic logic fits_line(input int unsigned off, input int unsigned len,
                                     input int unsigned blk);
    return (off + len) <= blk;
  endfunction

endpackage

// File: rtl/trk_line_table.sv
module trk_line_table #(
  parameter int DEPTH        = 8,
  parameter int LINE_W       = 10,
  parameter int TS_W         = 16,
  parameter int STALL_CYCLES = 1000,
  localparam int AGE_W       = $clog2(STALL_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] lk_line,
  output logic              lk_hit,
  output logic              full,
  input  logic              ins_en,
  input  logic [LINE_W-1:0] ins_line,
  input  logic [TS_W-1:0]   ins_stamp,
  input  logic              del_en,
  input  logic [LINE_W-1:0] del_line,
  output logic              warn_req,
  output logic [LINE_W-1:0] warn_line,
  output logic [TS_W-1:0]   warn_stamp,
  input  logic              warn_ack
);

  localparam logic [AGE_W-1:0] AGE_LIMIT = AGE_W'(STALL_CYCLES);

  logic [DEPTH-1:0]  vld_q, warned_q;
  logic [LINE_W-1:0] line_q  [DEPTH];
  logic [TS_W-1:0]   stamp_q [DEPTH];
  logic [AGE_W-1:0]  age_q   [DEPTH];

  logic [DEPTH-1:0]  lk_match, del_match, pend, alloc_oh, warn_oh;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      lk_match[i]  = vld_q[i] && (line_q[i] == lk_line);
      del_match[i] = del_en && vld_q[i] && (line_q[i] == del_line);
      pend[i]      = vld_q[i] && !warned_q[i] && (age_q[i] == AGE_LIMIT);
    end
  end

  assign lk_hit = |lk_match;
  assign full   = &vld_q;

  // lowest free slot and lowest pending warning
  always_comb begin
    logic got_free, got_warn;
    got_free   = 1'b0;
    got_warn   = 1'b0;
    alloc_oh   = '0;
    warn_oh    = '0;
    warn_line  = '0;
    warn_stamp = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld_q[i] && !got_free) begin
        alloc_oh[i] = 1'b1;
        got_free    = 1'b1;
      end
      if (pend[i] && !got_warn) begin
        warn_oh[i] = 1'b1;
        warn_line  = line_q[i];
        warn_stamp = stamp_q[i];
        got_warn   = 1'b1;
      end
    end
  end

  assign warn_req = |pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q    <= '0;
      warned_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        line_q[i]  <= '0;
        stamp_q[i] <= '0;
        age_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (del_match[i]) begin
          vld_q[i] <= 1'b0;
        end else if (ins_en && alloc_oh[i]) begin
          vld_q[i]    <= 1'b1;
          warned_q[i] <= 1'b0;
          line_q[i]   <= ins_line;
          stamp_q[i]  <= ins_stamp;
          age_q[i]    <= '0;
        end else if (vld_q[i]) begin
          if (age_q[i] != AGE_LIMIT) age_q[i] <= age_q[i] + 1'b1;
          if (warn_ack && warn_oh[i]) warned_q[i] <= 1'b1;
        end
      end
    end
  end

  // R6
  no_full_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);

  // R3
  no_dup_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && lk_line == ins_line) |-> !lk_hit);

  // R5
  one_entry_per_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    del_en |-> ($countones(del_match) <= 1));

  // R9
  ack_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warn_ack |-> warn_req);

endmodule

// File: rtl/trk_stall_pick.sv
module trk_stall_pick #(
  parameter int LINE_W = 10,
  parameter int TS_W   = 16
) (
  input  logic              wr_req,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [TS_W-1:0]   wr_stamp,
  input  logic              rd_req,
  input  logic [LINE_W-1:0] rd_line,
  input  logic [TS_W-1:0]   rd_stamp,
  output logic              wr_ack,
  output logic              rd_ack,
  output logic              any,
  output logic [LINE_W-1:0] line,
  output logic [TS_W-1:0]   stamp
);

  // write table has priority
  assign wr_ack = wr_req;
  assign rd_ack = rd_req && !wr_req;
  assign any    = wr_req || rd_req;
  assign line   = wr_req ? wr_line  : rd_line;
  assign stamp  = wr_req ? wr_stamp : rd_stamp;

endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import req_tracker_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int BLOCK_BYTES  = 64,
  parameter int DEPTH        = 8,
  parameter int ID_W         = 8,
  parameter int TS_W         = 16,
  parameter int STALL_CYCLES = 1000,
  localparam int OFF_W       = $clog2(BLOCK_BYTES),
  localparam int LEN_W       = OFF_W + 1,
  localparam int LINE_W      = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2:0]        req_kind,
  input  logic              cpl_valid,
  input  logic [ADDR_W-1:0] cpl_addr,
  output logic              resp_valid,
  output logic [1:0]        resp_status,
  output logic [ID_W-1:0]   resp_id,
  output logic              resp_data_back,
  output logic              stall_valid,
  output logic [LINE_W-1:0] stall_line,
  output logic [TS_W-1:0]   stall_stamp
);

  logic [LINE_W-1:0] req_line, cpl_line;
  logic [OFF_W-1:0]  req_off;
  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign req_off  = req_addr[OFF_W-1:0];
  assign cpl_line = cpl_addr[ADDR_W-1:OFF_W];

  logic [TS_W-1:0] stamp_q;
  logic [ID_W-1:0] id_q;

  // named events for checking
  logic malformed, wr_class, line_busy, class_full, accept, wr_ins, rd_ins;
  logic wr_hit, rd_hit, wr_full, rd_full;
  status_e status_d;

  assign malformed  = (req_kind == K_RSVD) ||
                      !fits_line(int'(req_off), int'(req_len), BLOCK_BYTES);
  assign wr_class   = is_write_class(req_kind);
  assign line_busy  = wr_hit || rd_hit;
  assign class_full = wr_class ? wr_full : rd_full;

  always_comb begin
    if (malformed)       status_d = ST_BAD;
    else if (line_busy)  status_d = ST_BUSY;
    else if (class_full) status_d = ST_FULL;
    else                 status_d = ST_ISSUE;
  end

  assign accept = req_valid && (status_d == ST_ISSUE);
  assign wr_ins = accept && wr_class;
  assign rd_ins = accept && !wr_class;

  logic              wr_wreq, rd_wreq, wr_ack, rd_ack, warn_any;
  logic [LINE_W-1:0] wr_wline, rd_wline, warn_line;
  logic [TS_W-1:0]   wr_wstamp, rd_wstamp, warn_stamp;

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    logic              hit_o, full_o, wreq_o, ack_i, ins_i;
    logic [LINE_W-1:0] wline_o;
    logic [TS_W-1:0]   wstamp_o;
    assign ins_i = (t == 0) ? wr_ins : rd_ins;
    assign ack_i = (t == 0) ? wr_ack : rd_ack;
    trk_line_table #(
      .DEPTH(DEPTH), .LINE_W(LINE_W), .TS_W(TS_W), .STALL_CYCLES(STALL_CYCLES)
    ) i_tbl (
      .clk(clk), .rst_n(rst_n),
      .lk_line(req_line), .lk_hit(hit_o), .full(full_o),
      .ins_en(ins_i), .ins_line(req_line), .ins_stamp(stamp_q),
      .del_en(cpl_valid), .del_line(cpl_line),
      .warn_req(wreq_o), .warn_line(wline_o), .warn_stamp(wstamp_o),
      .warn_ack(ack_i)
    );
  end

  assign wr_hit    = g_tbl[0].hit_o;
  assign wr_full   = g_tbl[0].full_o;
  assign wr_wreq   = g_tbl[0].wreq_o;
  assign wr_wline  = g_tbl[0].wline_o;
  assign wr_wstamp = g_tbl[0].wstamp_o;
  assign rd_hit    = g_tbl[1].hit_o;
  assign rd_full   = g_tbl[1].full_o;
  assign rd_wreq   = g_tbl[1].wreq_o;
  assign rd_wline  = g_tbl[1].wline_o;
  assign rd_wstamp = g_tbl[1].wstamp_o;

  trk_stall_pick #(.LINE_W(LINE_W), .TS_W(TS_W)) i_pick (
    .wr_req(wr_wreq), .wr_line(wr_wline), .wr_stamp(wr_wstamp),
    .rd_req(rd_wreq), .rd_line(rd_wline), .rd_stamp(rd_wstamp),
    .wr_ack(wr_ack), .rd_ack(rd_ack),
    .any(warn_any), .line(warn_line), .stamp(warn_stamp)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q        <= '0;
      id_q           <= '0;
      resp_valid     <= 1'b0;
      resp_status    <= ST_ISSUE;
      resp_id        <= '0;
      resp_data_back <= 1'b0;
      stall_valid    <= 1'b0;
      stall_line     <= '0;
      stall_stamp    <= '0;
    end else begin
      stamp_q        <= stamp_q + 1'b1;
      resp_valid     <= req_valid;
      resp_status    <= status_d;
      resp_id        <= id_q;
      resp_data_back <= returns_data(req_kind);
      if (accept) id_q <= id_q + 1'b1;
      stall_valid    <= warn_any;
      stall_line     <= warn_line;
      stall_stamp    <= warn_stamp;
    end
  end

  // R10
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid);

  // R10
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid);

  // R7
  id_steps_on_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && $past(accept) && $past(rst_n)) |=> (resp_id == $past(resp_id) + 1'b1));

endmodule

// File: tb/test_req_tracker.sv
module test_req_tracker;

  localparam int T = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic [6:0]  req_len = '0;
  logic [2:0]  req_kind = '0;
  logic        cpl_valid = 1'b0;
  logic [15:0] cpl_addr = '0;
  logic        resp_valid, resp_data_back, stall_valid;
  logic [1:0]  resp_status;
  logic [7:0]  resp_id;
  logic [9:0]  stall_line;
  logic [15:0] stall_stamp;

  always #2.5 clk = ~clk;

  req_tracker #(.STALL_CYCLES(T)) i_req_tracker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len), .req_kind(req_kind),
    .cpl_valid(cpl_valid), .cpl_addr(cpl_addr),
    .resp_valid(resp_valid), .resp_status(resp_status), .resp_id(resp_id),
    .resp_data_back(resp_data_back),
    .stall_valid(stall_valid), .stall_line(stall_line), .stall_stamp(stall_stamp)
  );

  int errors = 0;
  int checks = 0;
  int exp_id = 0;
  logic [15:0] cyc = '0;
  logic [15:0] last_stamp = '0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else cyc <= cyc + 1'b1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with response visible
  task automatic send(input logic [2:0] k, input logic [15:0] a, input logic [6:0] l,
                      input bit with_cpl, input logic [15:0] ca);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_len = l;
    cpl_valid = with_cpl; cpl_addr = ca;
    last_stamp = cyc;
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
  endtask

  task automatic expect_resp(input string tag, input int st, input int db);
    chk({tag, " resp_valid"}, resp_valid, 1);
    chk({tag, " status"}, resp_status, st);
    if (st == 0) begin
      chk({tag, " id"}, resp_id, exp_id);
      exp_id++;
      if (db >= 0) chk({tag, " data_back"}, resp_data_back, db);
    end
  endtask

  task automatic complete(input logic [15:0] a);
    cpl_valid = 1'b1; cpl_addr = a;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_id = 0;
  endtask

  // {kind[2:0], addr[15:0], len[6:0], status[1:0], data_back}
  localparam int NV = 13;
  localparam logic [28:0] VEC [NV] = '{
    {3'd0, 16'h0040, 7'd4,  2'd0, 1'b1},  // R2 R8 load issues
    {3'd2, 16'h0080, 7'd8,  2'd0, 1'b0},  // R2 R8 store issues
    {3'd0, 16'h0044, 7'd4,  2'd1, 1'b0},  // R3 same line busy
    {3'd2, 16'h0050, 7'd1,  2'd1, 1'b0},  // R3 busy across tables
    {3'd3, 16'h00C0, 7'd4,  2'd0, 1'b1},  // R8 atomic read returns data
    {3'd4, 16'h00C8, 7'd4,  2'd1, 1'b0},  // R3 atomic write same line
    {3'd5, 16'h0100, 7'd64, 2'd0, 1'b0},  // R4 whole line legal
    {3'd6, 16'h017C, 7'd4,  2'd0, 1'b0},  // R4 60+4 boundary legal
    {3'd2, 16'h01BD, 7'd4,  2'd3, 1'b0},  // R4 61+4 malformed
    {3'd7, 16'h0200, 7'd1,  2'd3, 1'b0},  // R4 reserved kind
    {3'd1, 16'h0240, 7'd2,  2'd0, 1'b1},  // R8 fetch returns data
    {3'd0, 16'h01C0, 7'd1,  2'd0, 1'b1},  // R7 id continues past refusals
    {3'd0, 16'h007F, 7'd2,  2'd3, 1'b0}   // R6 malformed ranks above busy
  };

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk("R1 resp_valid after reset", resp_valid, 0);
    chk("R1 stall_valid after reset", stall_valid, 0);

    for (int v = 0; v < NV; v++) begin
      logic [28:0] e;
      e = VEC[v];
      send(e[28:26], e[25:10], e[9:3], 1'b0, '0);
      expect_resp($sformatf("R3/R4/R8 vector %0d", v), int'(e[2:1]), int'(e[0]));
    end
    // R10: idle cycle gives no response
    @(negedge clk);
    chk("R10 no response when idle", resp_valid, 0);

    // occupancy and completion
    do_reset();
    @(negedge clk);
    for (int l = 16; l < 24; l++) begin
      send(3'd2, 16'(l << 6), 7'd4, 1'b0, '0);
      expect_resp("R6 fill write table", 0, 0);
    end
    send(3'd2, 16'(24 << 6), 7'd4, 1'b0, '0);
    expect_resp("R6 write table full", 2, -1);
    send(3'd0, 16'(24 << 6), 7'd4, 1'b0, '0);
    expect_resp("R2 read class unaffected by full write table", 0, 1);
    complete(16'(99 << 6));
    send(3'd2, 16'(26 << 6), 7'd4, 1'b0, '0);
    expect_resp("R5 absent completion frees nothing", 2, -1);
    complete(16'(16 << 6));
    send(3'd2, 16'(25 << 6), 7'd4, 1'b0, '0);
    expect_resp("R5 completion frees a slot", 0, 0);
    send(3'd2, 16'(24 << 6), 7'd4, 1'b0, '0);
    expect_resp("R6 busy ranks above full", 1, -1);
    send(3'd2, 16'(17 << 6), 7'd4, 1'b1, 16'(17 << 6));
    expect_resp("R3 lookup sees pre-completion state", 1, -1);
    send(3'd2, 16'(17 << 6), 7'd4, 1'b0, '0);
    expect_resp("R5 line reusable after completion", 0, 0);

    // stall warning
    do_reset();
    @(negedge clk);
    begin
      logic [15:0] sa, sb;
      int seen, na, nb;
      send(3'd0, 16'(5 << 6), 7'd4, 1'b0, '0);
      sa = last_stamp;
      send(3'd2, 16'(6 << 6), 7'd4, 1'b0, '0);
      sb = last_stamp;
      seen = 0; na = -1; nb = -1;
      for (int n = 1; n <= T + 8; n++) begin
        @(negedge clk);
        if (stall_valid) begin
          seen++;
          if (stall_line == 10'd5) begin
            na = n;
            chk("R9 stamp of first entry", stall_stamp, sa);
          end else if (stall_line == 10'd6) begin
            nb = n;
            chk("R9 stamp of second entry", stall_stamp, sb);
          end
        end
      end
      chk("R9 first warning cycle", na, T);
      chk("R9 second warning cycle", nb, T + 1);
      chk("R9 one warning per entry", seen, 2);
      complete(16'(5 << 6));
      complete(16'(6 << 6));
      send(3'd0, 16'(7 << 6), 7'd4, 1'b0, '0);
      repeat (4) @(negedge clk);
      complete(16'(7 << 6));
      seen = 0;
      for (int n = 0; n < T + 10; n++) begin
        @(negedge clk);
        if (stall_valid) seen++;
      end
      chk("R9 no warning for completed entry", seen, 0);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule